// File: doc/BRIEF.md
# Shared-Line Bus Ownership Arbiter

This block sits beside a CPU core and decides who drives the system bus. Another bus master, such as a block-transfer engine, sends a one-clock low pulse on a shared open-drain request wire to ask for the bus. The arbiter synchronizes the wire and finds that pulse by its falling edge. It then holds off new CPU bus cycles and lets the cycle in flight finish. Next it turns off the CPU's address, data and control drivers. One cycle later it answers on the same wire with a one-clock low grant pulse.

While the other master owns the bus, interrupt recognition is masked. Edges on the wire are ignored for a fixed float window after the grant. This keeps the arbiter from reading its own grant echo, or an early pulse, as a release. After the window, the next low pulse from the master is a release, and the CPU drivers come back on. If the master never starts a bus cycle, shown by the bus strobe, within a set number of cycles after the window, the arbiter takes the bus back by itself.

No data passes through this block, so it has no valid/ready interface. Every pin is a plain level control.

Top module: `bus_own_arbiter`

## Requirements
- R1: After reset, `addr_oe`, `data_oe` and `ctrl_oe` are 1, and `irq_mask`, `cpu_hold` and `bus_req_pull` are 0.
- R2: A low pulse on `bus_req_line` while the CPU owns the bus raises `irq_mask` and `cpu_hold` 3 clocks after the line is first sampled low. The drivers stay enabled for as long as `cpu_cycle_busy` is 1.
- R3: In the first cycle that `cpu_cycle_busy` is 0 after the request, the arbiter clears all three driver enables at the next edge. `bus_req_pull` (1 = pull the wire low) is then 1 for the following cycle, and never while a driver enable is 1.
- R4: Each handover produces exactly one grant, lasting one clock.
- R5: For FLOAT_CYC cycles after the grant (at least SYNC_STAGES+1), falling edges on the wire are ignored, including the grant's own echo. The bus stays with the other master.
- R6: A low pulse after the float window re-enables all three drivers and drops `irq_mask` and `cpu_hold` together, 3 clocks after the pulse is first sampled.
- R7: `irq_mask` and `cpu_hold` are 1 whenever the drivers are disabled.
- R8: If `bus_strobe` stays 0 for IDLE_LIMIT cycles after the float window, the drivers are re-enabled and the mask is dropped with no release pulse.
- R9: Once `bus_strobe` has been seen during ownership, no timeout occurs and the bus stays with the other master until it sends a release pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_line | input | 1 | Sampled level of the shared open-drain request wire (idle high) |
| bus_req_pull | output | 1 | 1 pulls the request wire low (the grant pulse) |
| cpu_cycle_busy | input | 1 | CPU bus cycle in progress |
| bus_strobe | input | 1 | Bus cycle start seen on the shared bus |
| cpu_hold | output | 1 | Stops the CPU from starting new bus cycles |
| addr_oe | output | 1 | CPU address driver enable |
| data_oe | output | 1 | CPU data driver enable |
| ctrl_oe | output | 1 | CPU control driver enable |
| irq_mask | output | 1 | Blocks interrupt recognition |

## Verification
The bound checker watches, on every cycle, the ordering of outputs around a handover:
- the grant appears only with the drivers off, one cycle after they turn off, and lasts one cycle;
- the drivers turn off only after an idle CPU cycle;
- the mask covers every cycle the drivers are off;
- the mask falls only when the drivers come back.

Only the bench scenarios can show the exact latencies from a pulse on the wire to each reaction. They also show that the grant echo and an early pulse inside the float window are ignored, and that the idle timeout fires only when no strobe was seen.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [2:0] {
    OWN_CPU    = 3'd0,
    OWN_DRAIN  = 3'd1,
    OWN_DETACH = 3'd2,
    OWN_GRANT  = 3'd3,
    OWN_FLOAT  = 3'd4,
    OWN_ALT    = 3'd5
  } own_state_e;
endpackage

// File: rtl/req_line_sync.sv
module req_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall_seen
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] stage_q;
  logic          prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= 1'b1;
          else        stage_q[gi] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= 1'b1;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= stage_q[LAST];
  end

  // a low pulse starts where the synchronized level goes from high to low
  assign fall_seen = prev_q & ~stage_q[LAST];
endmodule

// File: rtl/own_timer.sv
module own_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/own_fsm.sv
module own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_seen,
  input  logic       cpu_cycle_busy,
  input  logic       bus_strobe,
  input  logic       float_expired,
  input  logic       idle_expired,
  output own_state_e state,
  output logic       float_load,
  output logic       idle_load
);
  own_state_e state_q, state_d;
  logic       strobe_seen_q;

  always_comb begin
    state_d    = state_q;
    float_load = 1'b0;
    idle_load  = 1'b0;
    unique case (state_q)
      OWN_CPU:    if (fall_seen) state_d = OWN_DRAIN;
      OWN_DRAIN:  if (!cpu_cycle_busy) state_d = OWN_DETACH;
      OWN_DETACH: state_d = OWN_GRANT;
      OWN_GRANT: begin
        float_load = 1'b1;
        state_d    = OWN_FLOAT;
      end
      OWN_FLOAT: begin
        if (float_expired) begin
          idle_load = 1'b1;
          state_d   = OWN_ALT;
        end
      end
      OWN_ALT: begin
        if (fall_seen)
          state_d = OWN_CPU;
        else if (idle_expired && !strobe_seen_q && !bus_strobe)
          state_d = OWN_CPU;
      end
      default: state_d = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= OWN_CPU;
      strobe_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idle_load)
        strobe_seen_q <= 1'b0;
      else if (state_q == OWN_ALT && bus_strobe)
        strobe_seen_q <= 1'b1;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/bus_own_arbiter.sv
module bus_own_arbiter
  import bus_own_pkg::*;
#(
  parameter int FLOAT_CYC   = 4,
  parameter int IDLE_LIMIT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_line,
  output logic bus_req_pull,
  input  logic cpu_cycle_busy,
  input  logic bus_strobe,
  output logic cpu_hold,
  output logic addr_oe,
  output logic data_oe,
  output logic ctrl_oe,
  output logic irq_mask
);
  // the float window must outlast the echo of the own grant through the synchronizer
  localparam int FLOAT_MIN = SYNC_STAGES + 1;
  localparam int FLOAT_EFF = (FLOAT_CYC < FLOAT_MIN) ? FLOAT_MIN : FLOAT_CYC;
  localparam int IDLE_EFF  = (IDLE_LIMIT < 1) ? 1 : IDLE_LIMIT;
  localparam int FW        = $clog2(FLOAT_EFF + 1);
  localparam int IW        = $clog2(IDLE_EFF + 1);
  localparam logic [FW-1:0] FLOAT_RELOAD = FW'(FLOAT_EFF - 1);
  localparam logic [IW-1:0] IDLE_RELOAD  = IW'(IDLE_EFF - 1);

  logic       fall_seen;
  logic       float_load, idle_load;
  logic       float_expired, idle_expired;
  own_state_e state;
  logic       cpu_drives;

  req_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (bus_req_line),
    .fall_seen (fall_seen)
  );

  own_timer #(.W(FW)) u_float_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (float_load),
    .load_val (FLOAT_RELOAD),
    .expired  (float_expired)
  );

  own_timer #(.W(IW)) u_idle_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (idle_load),
    .load_val (IDLE_RELOAD),
    .expired  (idle_expired)
  );

  own_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .fall_seen      (fall_seen),
    .cpu_cycle_busy (cpu_cycle_busy),
    .bus_strobe     (bus_strobe),
    .float_expired  (float_expired),
    .idle_expired   (idle_expired),
    .state          (state),
    .float_load     (float_load),
    .idle_load      (idle_load)
  );

  assign cpu_drives   = (state == OWN_CPU) || (state == OWN_DRAIN);
  assign addr_oe      = cpu_drives;
  assign data_oe      = cpu_drives;
  assign ctrl_oe      = cpu_drives;
  assign cpu_hold     = (state != OWN_CPU);
  assign irq_mask     = (state != OWN_CPU);
  assign bus_req_pull = (state == OWN_GRANT);
endmodule

// File: rtl/bus_own_checker.sv
module bus_own_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_req_line,
  input logic bus_req_pull,
  input logic cpu_cycle_busy,
  input logic bus_strobe,
  input logic cpu_hold,
  input logic addr_oe,
  input logic data_oe,
  input logic ctrl_oe,
  input logic irq_mask
);
  a_r3_grant_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_pull |-> (!addr_oe && !data_oe && !ctrl_oe));

  a_r3_grant_follows_detach: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_pull |-> (!$past(addr_oe) && $past(addr_oe, 2)));

  a_r4_grant_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_pull |=> !bus_req_pull);

  a_r2_detach_after_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_oe) |-> !$past(cpu_cycle_busy));

  a_r7_mask_while_detached: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> (irq_mask && cpu_hold));

  a_r6_mask_drops_with_attach: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_mask) |-> $rose(addr_oe));
endmodule

bind bus_own_arbiter bus_own_checker u_chk (.*);

// File: tb/tb_bus_own_arbiter.sv
module tb_bus_own_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int FLOAT_CYC  = 6;
  localparam int IDLE_LIMIT = 20;
  localparam int EV_HOLD = 0, EV_DETACH = 1, EV_GRANT = 2, EV_ATTACH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_low = 1'b0;
  logic cpu_cycle_busy = 1'b0;
  logic bus_strobe = 1'b0;
  logic bus_req_pull, cpu_hold, addr_oe, data_oe, ctrl_oe, irq_mask;
  logic bus_req_line;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  int    q_kind[$];
  int    q_at[$];
  string q_tag[$];

  assign bus_req_line = ~(bus_req_pull | master_low);

  bus_own_arbiter #(.FLOAT_CYC(FLOAT_CYC), .IDLE_LIMIT(IDLE_LIMIT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req_line(bus_req_line), .bus_req_pull(bus_req_pull),
    .cpu_cycle_busy(cpu_cycle_busy), .bus_strobe(bus_strobe), .cpu_hold(cpu_hold),
    .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe), .irq_mask(irq_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_ev(input int kind, input int at, input string tag);
    q_kind.push_back(kind);
    q_at.push_back(at);
    q_tag.push_back(tag);
  endtask

  // monitor: turns output changes into events and compares them with the queue
  task automatic take_ev(input int kind);
    int ek, ea;
    string et;
    n_chk++;
    if (q_kind.size() == 0) begin
      n_fail++;
      $display("FAIL R4: unexpected event actual kind %0d at %0d expected none", kind, cyc);
    end else begin
      ek = q_kind.pop_front();
      ea = q_at.pop_front();
      et = q_tag.pop_front();
      if (ek != kind || ea != cyc) begin
        n_fail++;
        $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d", et, kind, cyc, ek, ea);
      end
    end
  endtask

  logic prev_mask = 1'b0, prev_oe = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_mask && irq_mask) take_ev(EV_HOLD);
      if (prev_oe && !addr_oe)    take_ev(EV_DETACH);
      if (!prev_pull && bus_req_pull) take_ev(EV_GRANT);
      if (!prev_oe && addr_oe) begin
        take_ev(EV_ATTACH);
        chk("R6 mask", int'(irq_mask), 0);
        chk("R6 hold", int'(cpu_hold), 0);
        chk("R6 data/ctrl", int'({data_oe, ctrl_oe}), 3);
      end
      if (prev_oe && !addr_oe) chk("R3 data/ctrl off", int'({data_oe, ctrl_oe}), 0);
      prev_mask <= irq_mask;
      prev_oe   <= addr_oe;
      prev_pull <= bus_req_pull;
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // called at a falling edge; line is low for one clock
  task automatic pulse_line(output int k);
    k = cyc;
    master_low = 1'b1;
    @(negedge clk);
    master_low = 1'b0;
  endtask

  task automatic strobe_once();
    bus_strobe = 1'b1;
    @(negedge clk);
    bus_strobe = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    int k, r, b0, o;
    repeat (4) @(negedge clk);
    chk("R1 addr_oe", int'(addr_oe), 1);
    chk("R1 data_oe", int'(data_oe), 1);
    chk("R1 ctrl_oe", int'(ctrl_oe), 1);
    chk("R1 irq_mask", int'(irq_mask), 0);
    chk("R1 cpu_hold", int'(cpu_hold), 0);
    chk("R1 pull", int'(bus_req_pull), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // S1: idle CPU, master uses the bus, long ownership survives past the idle limit
    pulse_line(k);
    push_ev(EV_HOLD, k + 3, "R2");
    push_ev(EV_DETACH, k + 4, "R3");
    push_ev(EV_GRANT, k + 5, "R3");
    o = k + 6 + FLOAT_CYC;
    wait_cyc(o);
    strobe_once();
    wait_cyc(o + IDLE_LIMIT + 5);
    chk("R9 still owned", int'(addr_oe), 0);
    pulse_line(r);
    push_ev(EV_ATTACH, r + 3, "R6");
    wait_cyc(r + 6);

    // S2: request while the CPU cycle is still running
    cpu_cycle_busy = 1'b1;
    pulse_line(k);
    push_ev(EV_HOLD, k + 3, "R2");
    wait_cyc(k + 7);
    chk("R2 drivers on while busy", int'(addr_oe), 1);
    chk("R2 hold while busy", int'(cpu_hold), 1);
    b0 = cyc;
    cpu_cycle_busy = 1'b0;
    push_ev(EV_DETACH, b0 + 1, "R3");
    push_ev(EV_GRANT, b0 + 2, "R3");
    o = b0 + 3 + FLOAT_CYC;
    wait_cyc(o + 1);
    strobe_once();
    pulse_line(r);
    push_ev(EV_ATTACH, r + 3, "R6");
    wait_cyc(r + 6);

    // S3: pulse inside the float window is ignored
    pulse_line(k);
    push_ev(EV_HOLD, k + 3, "R2");
    push_ev(EV_DETACH, k + 4, "R3");
    push_ev(EV_GRANT, k + 5, "R3");
    wait_cyc(k + 7);
    pulse_line(r);
    wait_cyc(k + 6 + FLOAT_CYC + 2);
    chk("R5 still owned", int'(addr_oe), 0);
    chk("R7 mask while owned", int'(irq_mask), 1);
    strobe_once();
    pulse_line(r);
    push_ev(EV_ATTACH, r + 3, "R6");
    wait_cyc(r + 6);

    // S4: grant never used, bus reclaimed
    pulse_line(k);
    push_ev(EV_HOLD, k + 3, "R2");
    push_ev(EV_DETACH, k + 4, "R3");
    push_ev(EV_GRANT, k + 5, "R3");
    push_ev(EV_ATTACH, k + 6 + FLOAT_CYC + IDLE_LIMIT, "R8");
    wait_cyc(k + 6 + FLOAT_CYC + IDLE_LIMIT + 4);

    chk("R4 pending events", q_kind.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule